// File: doc/BRIEF.md
# VLAN Table Command Engine

This block keeps a sixteen-entry VLAN membership table for an eight-port switch and puts it behind a small 32-bit register bus. Software never addresses the table directly. It stages an entry in two attribute registers and then writes a command word to a control register. The engine then copies the staged entry into the table, or copies a table entry back into the attribute registers. During this time a busy flag stays raised in the top bit of the control register, and software polls that bit until it drops.

The engine also holds a 12-bit VLAN identifier for each entry. These are packed two to a 32-bit word in a separate window. After reset, each identifier is preset to its own entry number. Forwarding logic next to the block reads the member mask, the valid flag and the per-port egress tag codes of any entry through a combinational lookup port, and this port does not touch the bus.

Top module: `vlan_cmd_engine`

## Requirements
- R1: A bus write to the control register (0x90) with bit 31 set starts a command when no command is running, and bit 31 of that register then reads 1. A control write with bit 31 clear starts nothing.
- R2: Busy (control bit 31) stays 1 for exactly CMD_LAT cycles after the starting write (4 by default) and then reads 0.
- R3: Command code 0, in control bits 14:12, loads the entry selected by control bits 11:0 into both attribute registers.
- R4: Command code 1 stores both attribute registers into the selected entry, and the change shows on the lookup port once busy has cleared.
- R5: Attribute register A (0x94) holds valid at bit 0, the 8-bit port member mask at bits 23:16, tag enable at bit 28 and independent-learning select at bit 30. All its other bits read 0.
- R6: Attribute register B (0x98) holds a 2-bit egress code for port j at bits [2j+1:2j], where 2'b00 means untagged and 2'b10 means tagged. Any stored code, including 01 and 11, comes back unchanged through a write command followed by a read command. Bits 31:16 read 0.
- R7: The identifier word k at 0x100+4k holds the identifier of entry 2k in bits 11:0 and of entry 2k+1 in bits 23:12. Bits 31:24 read 0, and the word can be read and written.
- R8: After reset, busy is 0, the control and attribute registers read 0, every table entry is all zero, and identifier i reads i.
- R9: A control write that arrives while busy is 1 is ignored. It changes neither the running command nor the index and code that the control register reads back.
- R10: A command whose index is 16 or more completes in the normal time and changes no table entry.
- R11: When a read command completes in the same cycle as a bus write to an attribute register, the value loaded from the table wins.
- R12: The lookup port returns the valid flag, member mask and egress codes of the entry on lk_idx in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| lk_idx | input | 4 | Entry selected for lookup |
| lk_valid | output | 1 | Valid flag of the selected entry |
| lk_member | output | 8 | Port member mask of the selected entry |
| lk_etag | output | 16 | Egress tag codes of the selected entry |

## Verification
Two events can fall on the same clock edge: the completion of a read command, which reloads the attribute registers from the table, and a software write to one of those attribute registers. The bench starts a read command on an entry with known contents. It then waits until the cycle just before completion, so that a write of zero to attribute register A lands on the completing edge. The bench judges the result by reading register A back: it must hold the table value, not the zero. A second contention, a new command word arriving while busy, is also provoked. It is judged by the index that the control register reads back and by the lookup contents of both entries involved.

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine #(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_PORTS   = 8,
  parameter int CMD_LAT     = 4,
  parameter int VID_W       = 12,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [15:0]            bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [IDX_W-1:0]       lk_idx,
  output logic                   lk_valid,
  output logic [NUM_PORTS-1:0]   lk_member,
  output logic [2*NUM_PORTS-1:0] lk_etag
);
  localparam logic [15:0] CTRL_A = 16'h0090;
  localparam logic [15:0] ATTA_A = 16'h0094;
  localparam logic [15:0] ATTB_A = 16'h0098;
  localparam logic [15:0] VID_A  = 16'h0100;
  localparam int NWORDS = NUM_ENTRIES / 2;
  localparam int WW     = IDX_W - 1;
  localparam int CNT_W  = $clog2(CMD_LAT + 1);
  localparam logic [2:0] OP_RD = 3'd0;
  localparam logic [2:0] OP_WR = 3'd1;

  logic                   busy;
  logic [CNT_W-1:0]       cnt;
  logic [2:0]             cmd_q;
  logic [11:0]            idx_q;
  logic                   a_valid, a_tag, a_ivl;
  logic [NUM_PORTS-1:0]   a_member;
  logic [2*NUM_PORTS-1:0] b_etag;

  logic [NUM_ENTRIES-1:0]                     t_valid, t_tag, t_ivl;
  logic [NUM_ENTRIES-1:0][NUM_PORTS-1:0]      t_member;
  logic [NUM_ENTRIES-1:0][2*NUM_PORTS-1:0]    t_etag;
  logic [NUM_ENTRIES-1:0][VID_W-1:0]          vid;

  wire              start  = bus_we && bus_addr == CTRL_A && bus_wdata[31] && !busy;
  wire              fin    = busy && cnt == '0;
  wire              in_rng = idx_q < 12'(NUM_ENTRIES);
  wire [IDX_W-1:0]  eidx   = idx_q[IDX_W-1:0];
  wire [13:0]       vword  = bus_addr[15:2] - VID_A[15:2];
  wire              vhit   = bus_addr[15:2] >= VID_A[15:2] && vword < 14'(NWORDS);
  wire [WW-1:0]     vw     = vword[WW-1:0];
  wire              unused_bits = &{1'b0, bus_wdata[29], bus_wdata[27:24],
                                    bus_wdata[15], bus_addr[1:0], vword};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; cmd_q <= '0; idx_q <= '0;
      a_valid <= 1'b0; a_tag <= 1'b0; a_ivl <= 1'b0; a_member <= '0; b_etag <= '0;
      t_valid <= '0; t_tag <= '0; t_ivl <= '0; t_member <= '0; t_etag <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) vid[i] <= VID_W'(i);
    end else begin
      if (start) begin
        busy  <= 1'b1;
        cnt   <= CNT_W'(CMD_LAT - 1);
        cmd_q <= bus_wdata[14:12];
        idx_q <= bus_wdata[11:0];
      end else if (busy) begin
        if (fin) busy <= 1'b0;
        else     cnt  <= cnt - 1'b1;
      end

      if (bus_we && bus_addr == ATTA_A) begin
        a_valid  <= bus_wdata[0];
        a_member <= bus_wdata[16 +: NUM_PORTS];
        a_tag    <= bus_wdata[28];
        a_ivl    <= bus_wdata[30];
      end
      if (bus_we && bus_addr == ATTB_A) b_etag <= bus_wdata[2*NUM_PORTS-1:0];

      if (fin && in_rng && cmd_q == OP_RD) begin
        a_valid  <= t_valid[eidx];
        a_member <= t_member[eidx];
        a_tag    <= t_tag[eidx];
        a_ivl    <= t_ivl[eidx];
        b_etag   <= t_etag[eidx];
      end
      if (fin && in_rng && cmd_q == OP_WR) begin
        t_valid[eidx]  <= a_valid;
        t_member[eidx] <= a_member;
        t_tag[eidx]    <= a_tag;
        t_ivl[eidx]    <= a_ivl;
        t_etag[eidx]   <= b_etag;
      end

      if (bus_we && vhit) begin
        vid[{vw, 1'b0}] <= bus_wdata[VID_W-1:0];
        vid[{vw, 1'b1}] <= bus_wdata[2*VID_W-1:VID_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_A)
      bus_rdata = {busy, 16'b0, cmd_q, idx_q};
    else if (bus_addr == ATTA_A) begin
      bus_rdata[0]                = a_valid;
      bus_rdata[16 +: NUM_PORTS]  = a_member;
      bus_rdata[28]               = a_tag;
      bus_rdata[30]               = a_ivl;
    end else if (bus_addr == ATTB_A)
      bus_rdata[2*NUM_PORTS-1:0] = b_etag;
    else if (vhit)
      bus_rdata[2*VID_W-1:0] = {vid[{vw, 1'b1}], vid[{vw, 1'b0}]};
  end

  assign lk_valid  = t_valid[lk_idx];
  assign lk_member = t_member[lk_idx];
  assign lk_etag   = t_etag[lk_idx];

  logic [CNT_W:0] run_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R2
  lat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_cnt < (CNT_W+1)'(CMD_LAT));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> $stable(cmd_q) && $stable(idx_q));

  // R10
  oob_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !in_rng) |=> $stable(t_member) && $stable(t_valid) && $stable(t_etag));

  // R4
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && in_rng && cmd_q == OP_WR) |=>
      t_member[$past(eidx)] == $past(a_member) && t_etag[$past(eidx)] == $past(b_etag));

  // R11
  rd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && in_rng && cmd_q == OP_RD) |=> a_member == $past(t_member[eidx]));
endmodule

// File: tb/vlan_cmd_engine_tb_top.sv
`timescale 1ns/100ps
module vlan_cmd_engine_tb_top;
  localparam int LAT = 4;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [3:0]  lk_idx = '0;
  logic        lk_valid;
  logic [7:0]  lk_member;
  logic [15:0] lk_etag;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  vlan_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lk_idx(lk_idx),
    .lk_valid(lk_valid), .lk_member(lk_member), .lk_etag(lk_etag));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic look(input int i, output logic [31:0] m, output logic [31:0] e);
    lk_idx = 4'(i); #1; m = {23'b0, lk_valid, lk_member}; e = {16'b0, lk_etag};
  endtask

  task automatic run_cmd(input logic [31:0] c);
    wr(16'h0090, c);
    repeat (LAT) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v, m, e;
    rd(16'h0090, v); chk("R8 ctrl", v, 0);
    rd(16'h0094, v); chk("R8 attrA", v, 0);
    rd(16'h0098, v); chk("R8 attrB", v, 0);
    rd(16'h0100, v); chk("R8 vid w0", v, 32'h0000_1000);
    rd(16'h011C, v); chk("R8 vid w7", v, 32'h0000_F00E);
    look(0, m, e);   chk("R8 entry0", m | e, 0);
  endtask

  task automatic t_write_cmd;
    logic [31:0] v, m, e;
    wr(16'h0094, 32'h505A_0001);
    wr(16'h0098, 32'h0000_8008);
    wr(16'h0090, 32'h0000_1006);
    rd(16'h0090, v); chk("R1 no start without bit31", v, 0);
    wr(16'h0090, 32'h8000_1005);
    rd(16'h0090, v); chk("R1 busy set", v[31], 1);
    repeat (LAT - 1) @(negedge clk);
    rd(16'h0090, v); chk("R2 busy last cycle", v[31], 1);
    @(negedge clk);
    rd(16'h0090, v); chk("R2 busy cleared", v, 32'h0000_1005);
    look(5, m, e);
    chk("R4 member+valid", m, 32'h15A);
    chk("R4 etag", e, 32'h8008);
    lk_idx = 4'd6; #1; chk("R12 lookup other entry", {lk_valid, lk_member}, 0);
    lk_idx = 4'd5; #1; chk("R12 lookup same cycle", {24'b0, lk_member}, 32'h5A);
  endtask

  task automatic t_layout;
    logic [31:0] v;
    wr(16'h0094, 32'hFFFF_FFFF); rd(16'h0094, v); chk("R5 attrA fields", v, 32'h50FF_0001);
    wr(16'h0098, 32'hFFFF_FFFF); rd(16'h0098, v); chk("R6 attrB width", v, 32'h0000_FFFF);
  endtask

  task automatic t_read_cmd;
    logic [31:0] v;
    wr(16'h0094, 0); wr(16'h0098, 0);
    run_cmd(32'h8000_0005);
    rd(16'h0094, v); chk("R3 attrA loaded", v, 32'h505A_0001);
    rd(16'h0098, v); chk("R3 attrB loaded", v, 32'h0000_8008);
    wr(16'h0094, 32'h0001_0001); wr(16'h0098, 32'h0000_0034);
    run_cmd(32'h8000_1009);
    wr(16'h0098, 0);
    run_cmd(32'h8000_0009);
    rd(16'h0098, v); chk("R6 odd codes kept", v, 32'h0000_0034);
  endtask

  task automatic t_vid;
    logic [31:0] v;
    wr(16'h0108, 32'hFFAB_C123);
    rd(16'h0108, v); chk("R7 vid pack", v, 32'h00AB_C123);
    rd(16'h010C, v); chk("R7 neighbour word", v, 32'h0000_7006);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v, m, e;
    wr(16'h0094, 32'h0011_0001); wr(16'h0098, 0);
    wr(16'h0090, 32'h8000_1003);
    wr(16'h0090, 32'h8000_1007);
    repeat (LAT) @(negedge clk);
    rd(16'h0090, v); chk("R9 ctrl keeps first", v, 32'h0000_1003);
    look(3, m, e);   chk("R9 entry3 written", m, 32'h111);
    look(7, m, e);   chk("R9 entry7 untouched", m, 0);
  endtask

  task automatic t_oob;
    logic [31:0] v, m, e;
    int bad = 0;
    wr(16'h0094, 32'h00FF_0001);
    run_cmd(32'h8000_1010);
    rd(16'h0090, v); chk("R10 completes", v, 32'h0000_1010);
    for (int i = 0; i < 16; i++) begin
      look(i, m, e);
      if (m[7:0] == 8'hFF) bad++;
    end
    chk("R10 no entry changed", bad, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(16'h0090, 32'h8000_0005);
    repeat (LAT - 1) @(negedge clk);
    wr(16'h0094, 32'h0000_0000);
    rd(16'h0094, v); chk("R11 table wins", v, 32'h505A_0001);
    wr(16'h0094, 32'h0000_0000);
    rd(16'h0094, v); chk("R11 later write lands", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_cmd();
    t_layout();
    t_read_cmd();
    t_vid();
    t_busy_ignore();
    t_oob();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule